// File: doc/BRIEF.md
# Double-Buffered Biquad Coefficient Bank

This block keeps two full coefficient sets for a cascaded second-order filter engine. At any time one set is live and feeds the filter datapath through a registered read port. The other is a shadow set that a control-side writer fills one word at a time. Each set holds a single global input gain, a count of the sections in use, and four recursive/feed-forward coefficients for every section.

When the writer has finished the shadow set it pulses a commit strobe, which raises an update-pending flag. The block counts sample-done strobes from the filter. On the strobe that ends a frame, if an update is pending, the two sets exchange roles and the flag drops on the same clock edge. The filter therefore always runs a whole frame on one consistent set and never sees a partial update. While an update is pending, the shadow set is locked: writes to it are refused and reported.

Top module: `coef_bank_swap`

## Requirements
- R1: After reset, bank 0 is live, no update is pending, `b0_out` equals unity (1 << COEF_FRAC), `nsect_out` is 0, `wr_err` is 0, and every section read returns zero on all four coefficient outputs.
- R2: An accepted write changes only the shadow bank. `b0_out`, `nsect_out` and the section reads stay unchanged until a swap happens.
- R3: A `wr_commit` pulse sets `upd_pending`, which is visible after the next clock edge.
- R4: The frame boundary is the `sample_done` strobe that completes FRAME_LEN strobes. At a boundary with an update pending, `active_bank` toggles and `upd_pending` clears on the same edge. At a boundary with no update pending, nothing changes.
- R5: A write while an update is pending is rejected. `wr_err` is 1 in the cycle after that write, and the rejected value never reaches the live set after the swap.
- R6: A commit that arrives in the swap cycle is not lost. `upd_pending` is still 1 after that swap, and the next boundary performs another swap.
- R7: A write to an address at or above 2 + 4*MAX_SECT is rejected and gives `wr_err` = 1 in the next cycle. An accepted write gives `wr_err` = 0.
- R8: A section-count write (address 1) is clamped to MAX_SECT. A section read at an index at or above the live count returns zero on all four coefficient outputs.
- R9: The write address map is: address 0 holds the global gain, address 1 holds the section count, and address 2 + 4*s + k holds lane k of section s, with lanes in the order b1=0, b2=1, a1=2, a2=3. A section read presented before a clock edge delivers the live coefficients after that edge.
- R10: `sample_done` strobes before the last one of a frame never cause a swap, even with an update pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the shadow bank |
| wr_addr | input | ADDR_W | Word address (map in R9) |
| wr_data | input | COEF_W | Write data |
| wr_commit | input | 1 | Shadow bank complete; request swap |
| wr_err | output | 1 | Previous write was rejected |
| sample_done | input | 1 | Filter finished one sample |
| rd_sect | input | SECT_W | Section index to read |
| rd_b1 | output | COEF_W | Live b1 of the read section |
| rd_b2 | output | COEF_W | Live b2 of the read section |
| rd_a1 | output | COEF_W | Live a1 of the read section |
| rd_a2 | output | COEF_W | Live a2 of the read section |
| b0_out | output | COEF_W | Live global gain |
| nsect_out | output | CNT_W | Live section count |
| active_bank | output | 1 | Index of the live bank |
| upd_pending | output | 1 | Update waiting for the frame boundary |

## Verification
The bench builds the block with COEF_W=16, COEF_FRAC=14, MAX_SECT=4 and FRAME_LEN=4. A four-sample frame lets many swaps happen in a short run, and four sections make the whole address map, including the first illegal address, easy to cover. These sizes bring several cases within reach: a frame boundary that arrives with and without a pending update, a commit that coincides with the last sample, and count clamping at a section count small enough to leave stored data beyond it. They also cover reads masked by that count and locked-shadow rejections, each checked after the next swap.

// File: rtl/coef_bank_pkg.sv
package coef_bank_pkg;
  localparam int NUM_LANES = 4;
  localparam int HDR_WORDS = 2;
  typedef enum logic [1:0] {
    LANE_B1 = 2'd0,
    LANE_B2 = 2'd1,
    LANE_A1 = 2'd2,
    LANE_A2 = 2'd3
  } lane_e;
endpackage

// File: rtl/coef_lane_ram.sv
module coef_lane_ram #(
  parameter int W  = 24,
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/coef_bank_ctrl.sv
module coef_bank_ctrl #(
  parameter int FRAME_LEN = 32,
  localparam int FC_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic sample_done,
  input  logic commit,
  output logic boundary,
  output logic act_q,
  output logic pend_q
);
  logic [FC_W-1:0] cnt_q;
  logic            last;

  assign last     = (cnt_q == FC_W'(FRAME_LEN - 1));
  assign boundary = sample_done && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (sample_done) cnt_q <= last ? '0 : cnt_q + 1'b1;
      if (boundary && pend_q) begin
        act_q  <= ~act_q;
        pend_q <= commit;
      end else if (commit) begin
        pend_q <= 1'b1;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!act_q && !pend_q));
  assert_swap_flips_R4: assert property (@(posedge clk) disable iff (rst)
    (boundary && pend_q) |=> (act_q != $past(act_q)));
  assert_no_swap_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !(boundary && pend_q) |=> $stable(act_q));
  assert_swap_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (boundary && pend_q && !commit) |=> !pend_q);
  assert_commit_held_R6: assert property (@(posedge clk) disable iff (rst)
    (boundary && pend_q && commit) |=> pend_q);
  assert_commit_sets_R3: assert property (@(posedge clk) disable iff (rst)
    commit |=> pend_q);
  assert_mid_frame_R10: assert property (@(posedge clk) disable iff (rst)
    (sample_done && !last) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/coef_bank_swap.sv
module coef_bank_swap
  import coef_bank_pkg::*;
#(
  parameter int COEF_W    = 24,
  parameter int COEF_FRAC = 22,
  parameter int MAX_SECT  = 8,
  parameter int FRAME_LEN = 32,
  localparam int NUM_ENT  = HDR_WORDS + NUM_LANES * MAX_SECT,
  localparam int ADDR_W   = $clog2(NUM_ENT),
  localparam int SECT_W   = (MAX_SECT > 1) ? $clog2(MAX_SECT) : 1,
  localparam int CNT_W    = $clog2(MAX_SECT + 1),
  localparam int RAM_AW   = SECT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [COEF_W-1:0] wr_data,
  input  logic              wr_commit,
  output logic              wr_err,
  input  logic              sample_done,
  input  logic [SECT_W-1:0] rd_sect,
  output logic [COEF_W-1:0] rd_b1,
  output logic [COEF_W-1:0] rd_b2,
  output logic [COEF_W-1:0] rd_a1,
  output logic [COEF_W-1:0] rd_a2,
  output logic [COEF_W-1:0] b0_out,
  output logic [CNT_W-1:0]  nsect_out,
  output logic              active_bank,
  output logic              upd_pending
);
  localparam logic [COEF_W-1:0] UNITY = COEF_W'(1) << COEF_FRAC;

  logic              act, pend, boundary, shadow;
  logic              addr_ok, wr_ok, is_coef;
  logic [ADDR_W-1:0] off;
  logic [SECT_W-1:0] wsect;
  logic [1:0]        wlane;
  logic [CNT_W-1:0]  cnt_clamped;
  logic [NUM_LANES-1:0] lane_we;
  logic [COEF_W-1:0] lane_q [NUM_LANES];
  logic [COEF_W-1:0] b0_r [2];
  logic [CNT_W-1:0]  nsect_r [2];
  logic              err_q, in_rng_q;

  coef_bank_ctrl #(.FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .sample_done(sample_done), .commit(wr_commit),
    .boundary(boundary), .act_q(act), .pend_q(pend)
  );

  assign shadow  = ~act;
  assign addr_ok = (int'(wr_addr) < NUM_ENT);
  assign wr_ok   = wr_en && !pend && addr_ok;
  assign is_coef = (int'(wr_addr) >= HDR_WORDS);
  assign off     = wr_addr - ADDR_W'(HDR_WORDS);
  assign wsect   = SECT_W'(off >> 2);
  assign wlane   = off[1:0];
  assign cnt_clamped = (int'(wr_data) > MAX_SECT) ? CNT_W'(MAX_SECT)
                                                  : CNT_W'(wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      b0_r[0]    <= UNITY;
      b0_r[1]    <= UNITY;
      nsect_r[0] <= '0;
      nsect_r[1] <= '0;
      err_q      <= 1'b0;
      in_rng_q   <= 1'b0;
    end else begin
      if (wr_ok && wr_addr == ADDR_W'(0)) b0_r[shadow]    <= wr_data;
      if (wr_ok && wr_addr == ADDR_W'(1)) nsect_r[shadow] <= cnt_clamped;
      err_q    <= wr_en && !wr_ok;
      in_rng_q <= (int'(rd_sect) < int'(nsect_r[act]));
    end
  end

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    assign lane_we[k] = wr_ok && is_coef && (wlane == 2'(k));
    coef_lane_ram #(.W(COEF_W), .AW(RAM_AW)) u_ram (
      .clk(clk), .we(lane_we[k]), .waddr({shadow, wsect}), .wdata(wr_data),
      .raddr({act, rd_sect}), .rdata(lane_q[k])
    );
  end

  assign rd_b1 = in_rng_q ? lane_q[LANE_B1] : '0;
  assign rd_b2 = in_rng_q ? lane_q[LANE_B2] : '0;
  assign rd_a1 = in_rng_q ? lane_q[LANE_A1] : '0;
  assign rd_a2 = in_rng_q ? lane_q[LANE_A2] : '0;
  assign b0_out      = b0_r[act];
  assign nsect_out   = nsect_r[act];
  assign active_bank = act;
  assign upd_pending = pend;
  assign wr_err      = err_q;

  assert_reject_pending_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && pend) |=> wr_err);
  assert_reject_range_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_ok) |=> wr_err);
  assert_count_limit_R8: assert property (@(posedge clk) disable iff (rst)
    int'(nsect_out) <= MAX_SECT);
  assert_one_lane_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_we));
  assert_live_gain_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !(boundary && pend) |=> $stable(b0_out));
endmodule

// File: tb/sim_coef_bank_swap.sv
module sim_coef_bank_swap;
  localparam int CLK_P = 10;
  localparam int CW = 16, FR = 14, MS = 4, FL = 4;
  localparam int AW = 5, SW = 2, NW = 3;
  localparam int UNITY = 1 << FR;
  // {sect[3:0], lane[3:0], data[15:0]}, lanes b1=0 b2=1 a1=2 a2=3
  localparam logic [23:0] VEC [8] = '{
    24'h00_1111, 24'h03_2A2A, 24'h11_0F0F, 24'h12_7001,
    24'h20_8123, 24'h23_0042, 24'h31_5555, 24'h32_FEDC};

  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_commit = 0, sample_done = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [SW-1:0] rd_sect = '0;
  logic wr_err, active_bank, upd_pending;
  logic [CW-1:0] rd_b1, rd_b2, rd_a1, rd_a2, b0_out;
  logic [NW-1:0] nsect_out;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  coef_bank_swap #(.COEF_W(CW), .COEF_FRAC(FR), .MAX_SECT(MS), .FRAME_LEN(FL)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .wr_err(wr_err), .sample_done(sample_done),
    .rd_sect(rd_sect), .rd_b1(rd_b1), .rd_b2(rd_b2), .rd_a1(rd_a1), .rd_a2(rd_a2),
    .b0_out(b0_out), .nsect_out(nsect_out), .active_bank(active_bank),
    .upd_pending(upd_pending));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data);
    wr_en = 1; wr_addr = AW'(addr); wr_data = CW'(data);
    cyc();
    wr_en = 0;
  endtask

  task automatic commit();
    wr_commit = 1; cyc(); wr_commit = 0;
  endtask

  task automatic frame(input bit commit_last);
    for (int i = 0; i < FL; i++) begin
      sample_done = 1;
      if (i == FL - 1) wr_commit = commit_last;
      cyc();
    end
    sample_done = 0; wr_commit = 0;
  endtask

  task automatic rd(input int s);
    rd_sect = SW'(s); cyc();
  endtask

  function automatic int pick(input int lane);
    case (lane)
      0: return int'(rd_b1);
      1: return int'(rd_b2);
      2: return int'(rd_a1);
      default: return int'(rd_a2);
    endcase
  endfunction

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(); cyc(); rst = 0; cyc();
    // R1 reset state
    chk("R1 active", active_bank, 0);
    chk("R1 pending", upd_pending, 0);
    chk("R1 b0", b0_out, UNITY);
    chk("R1 nsect", nsect_out, 0);
    chk("R1 err", wr_err, 0);
    rd(0);
    chk("R1 read b1", rd_b1, 0);
    chk("R1 read a2", rd_a2, 0);

    // table load into shadow bank 1
    wr(0, 8000); wr(1, 4);
    for (int i = 0; i < 8; i++) begin
      wr(2 + 4 * int'(VEC[i][23:20]) + int'(VEC[i][19:16]), int'(VEC[i][15:0]));
      chk("R7 accepted write", wr_err, 0);
    end
    chk("R2 b0 unchanged", b0_out, UNITY);
    chk("R2 nsect unchanged", nsect_out, 0);
    rd(1);
    chk("R2 read unchanged", rd_b2, 0);
    commit();
    chk("R3 pending set", upd_pending, 1);
    for (int i = 0; i < FL - 1; i++) begin
      sample_done = 1; cyc();
    end
    sample_done = 0;
    chk("R10 no mid-frame swap", active_bank, 0);
    chk("R10 still pending", upd_pending, 1);
    sample_done = 1; cyc(); sample_done = 0;
    chk("R4 swapped", active_bank, 1);
    chk("R4 pending cleared", upd_pending, 0);
    chk("R4 b0 live", b0_out, 8000);
    chk("R4 nsect live", nsect_out, 4);
    for (int i = 0; i < 8; i++) begin
      rd(int'(VEC[i][23:20]));
      chk("R9 table read", pick(int'(VEC[i][19:16])), int'(VEC[i][15:0]));
    end

    // R4 boundary without pending
    frame(0);
    chk("R4 idle boundary", active_bank, 1);

    // R5 locked shadow (bank 0)
    wr(0, 1234); commit();
    wr(0, 999);
    chk("R5 reject err", wr_err, 1);
    frame(0);
    chk("R5 swap to bank0", active_bank, 0);
    chk("R5 rejected value absent", b0_out, 1234);

    // R7 out of range
    wr(18, 5);
    chk("R7 addr 18 err", wr_err, 1);
    wr(31, 5);
    chk("R7 addr 31 err", wr_err, 1);

    // R8 clamp (shadow bank 1)
    wr(1, 7); commit(); frame(0);
    chk("R8 clamped", nsect_out, 4);
    // R9 second lane map check in bank 0, section 1
    wr(1, 2); wr(6, 101); wr(7, 202); wr(8, 303); wr(9, 404);
    commit(); frame(0);
    chk("R9 active bank0", active_bank, 0);
    rd(1);
    chk("R9 b1", rd_b1, 101);
    chk("R9 b2", rd_b2, 202);
    chk("R9 a1", rd_a1, 303);
    chk("R9 a2", rd_a2, 404);
    // R8 masking: bank 1 with count 1 keeps data in section 3
    wr(1, 1); commit(); frame(0);
    rd(3);
    chk("R8 masked b2", rd_b2, 0);
    chk("R8 masked a1", rd_a1, 0);
    rd(0);
    chk("R8 in-range b1", rd_b1, 16'h1111);

    // R6 commit in swap cycle
    commit(); frame(1);
    chk("R6 swapped", active_bank, 0);
    chk("R6 pending held", upd_pending, 1);
    frame(0);
    chk("R6 second swap", active_bank, 1);
    chk("R6 pending clear", upd_pending, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule